// File: doc/BRIEF.md
# Nibble-Serialized Timer Compare/Capture Port

This block holds an 8-bit free-running counter and moves its two 8-bit registers over a narrow 4-bit indirect port. The host selects a subport with a 4-bit address. At subport 9 hex a write reaches the compare register and a read reaches the capture register. Each register takes two bus accesses.

A compare value arrives low nibble first. The low nibble waits in a holding register, and the new value is committed only when the high nibble arrives. While the write is half done, and before any full value has ever been written, no interrupt is raised. After that, a counter value equal to the committed compare value produces a one-cycle interrupt request.

A capture read goes the other way round, high nibble first. The first read takes a snapshot of the counter and returns its upper half in the same cycle. The second read returns the lower half of that snapshot while the counter keeps running. In the pulse-density mode the snapshot is stored bit-reversed. If the timer is halted after an interrupt event, the snapshot is cleared.

Top module: `nibble_timer_port`

## Requirements
- R1: After reset the counter is zero. While `run_i` is high it advances by one on every clock (wrapping at 255). While `run_i` is low it holds its value.
- R2: Writes at subport 9 hex load the compare register in two accesses, low nibble first and then high nibble. The value `{high, low}` takes effect from the clock after the high nibble is written.
- R3: While running, `irq_o` is high for exactly one cycle, in the cycle after the one in which the counter equals the committed compare value.
- R4: No interrupt is raised before the first complete two-nibble compare write. None is raised between the low-nibble write and the high-nibble write, even when the counter passes the old compare value.
- R5: Reads at subport 9 hex return data on `rdata_o` in the same cycle as the read strobe. The first read returns bits 7..4 of the counter value in that cycle and snapshots all 8 bits. The second read returns bits 3..0 of the snapshot.
- R6: The snapshot stays unchanged from the first read to the second read while the counter keeps counting.
- R7: When `pdm_mode_i` is high at the first read, the snapshot is stored bit-reversed: snapshot bit i holds counter bit 7-i.
- R8: The capture register resets to zero. If `run_i` is low in a cycle after an interrupt has been raised since the last halt, the capture register is cleared to zero on that clock.
- R9: Accesses at any subport other than 9 hex change no state. `rdata_o` is zero in every cycle without a read at subport 9 hex.
- R10: The write-phase and read-phase flags each toggle on every access at subport 9 hex in their own direction. Each returns to the first-nibble phase after its second access and on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter runs when high, halts when low |
| pdm_mode_i | input | 1 | Selects bit-reversed capture |
| sub_addr_i | input | 4 | Indirect subport address |
| wr_i | input | 1 | Write strobe for one nibble |
| wdata_i | input | 4 | Write nibble |
| rd_i | input | 1 | Read strobe for one nibble |
| rdata_o | output | 4 | Read nibble, valid in the strobe cycle |
| irq_o | output | 1 | One-cycle compare interrupt request |

## Verification
Read data is combinational, so the scoreboard compares `rdata_o` in the same cycle as the strobe, shortly after the falling edge. Its expected value comes from a bench-side model of the counter and snapshot. The interrupt is due one clock after the counter matches, and the compare register changes one clock after the high-nibble strobe. The bench therefore updates its model of the phase and compare state just after each rising edge and compares `irq_o` against a registered model value on every cycle. The clearing on halt is due on the first rising edge with `run_i` low, so the second read that observes it is issued at least one full cycle after the halt.

// File: rtl/ntp_pkg.sv
package ntp_pkg;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned ADDR_W  = 4;
    localparam logic [3:0]  SUB_SEL = 4'h9;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;
endpackage

// File: rtl/ntp_counter.sv
module ntp_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            st_d.cnt = st_q.cnt + {{(W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/ntp_wr_seq.sv
module ntp_wr_seq
    import ntp_pkg::*;
#(
    parameter int unsigned NW = 4,
    localparam int unsigned W = 2 * NW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hit_i,
    input  logic [NW-1:0] nib_i,
    input  logic [W-1:0]  cnt_i,
    input  logic          run_i,
    output logic          irq_o,
    output phase_e        phase_o,
    output logic          armed_o
);
    typedef struct packed {
        phase_e        ph;
        logic [NW-1:0] hold;
        logic [W-1:0]  cmp;
        logic          armed;
        logic          irq;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // match only with a committed value and no half-written update pending
        st_d.irq = run_i && st_q.armed && (st_q.ph == PH_FIRST) && (cnt_i == st_q.cmp);
        if (hit_i) begin
            if (st_q.ph == PH_FIRST) begin
                st_d.hold = nib_i;
                st_d.ph   = PH_SECOND;
            end else begin
                st_d.cmp   = {nib_i, st_q.hold};
                st_d.armed = 1'b1;
                st_d.ph    = PH_FIRST;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o   = st_q.irq;
    assign phase_o = st_q.ph;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/ntp_rd_seq.sv
module ntp_rd_seq
    import ntp_pkg::*;
#(
    parameter int unsigned NW = 4,
    localparam int unsigned W = 2 * NW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hit_i,
    input  logic          pdm_i,
    input  logic          run_i,
    input  logic          irq_i,
    input  logic [W-1:0]  cnt_i,
    output logic [NW-1:0] rdata_o,
    output phase_e        phase_o,
    output logic [W-1:0]  cap_o
);
    typedef struct packed {
        phase_e       ph;
        logic [W-1:0] cap;
        logic         evt;
    } rd_st_t;

    rd_st_t       st_d, st_q;
    logic [W-1:0] cnt_rev;
    logic [W-1:0] snap;

    for (genvar gi = 0; gi < W; gi++) begin : g_rev
        assign cnt_rev[gi] = cnt_i[W-1-gi];
    end

    assign snap = pdm_i ? cnt_rev : cnt_i;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        if (hit_i) begin
            if (st_q.ph == PH_FIRST) begin
                rdata_o  = snap[W-1:NW];
                st_d.cap = snap;
                st_d.ph  = PH_SECOND;
            end else begin
                rdata_o = st_q.cap[NW-1:0];
                st_d.ph = PH_FIRST;
            end
        end
        if (irq_i) begin
            st_d.evt = 1'b1;
        end
        // halting after an interrupt event wipes the snapshot
        if (!run_i && st_q.evt) begin
            st_d.cap = '0;
            st_d.evt = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign cap_o   = st_q.cap;
endmodule

// File: rtl/nibble_timer_port.sv
module nibble_timer_port
    import ntp_pkg::*;
#(
    parameter int unsigned NW = NIB_W,
    parameter int unsigned AW = ADDR_W,
    parameter logic [AW-1:0] SEL = AW'(SUB_SEL),
    localparam int unsigned W = 2 * NW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          pdm_mode_i,
    input  logic [AW-1:0] sub_addr_i,
    input  logic          wr_i,
    input  logic [NW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [NW-1:0] rdata_o,
    output logic          irq_o
);
    logic         sel;
    logic         wr_hit;
    logic         rd_hit;
    logic [W-1:0] cnt;
    logic [W-1:0] cap;
    logic         armed;
    phase_e       wr_ph;
    phase_e       rd_ph;

    assign sel    = (sub_addr_i == SEL);
    assign wr_hit = wr_i && sel;
    assign rd_hit = rd_i && sel;

    ntp_counter #(.W(W)) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run_i),
        .cnt_o (cnt)
    );

    ntp_wr_seq #(.NW(NW)) u_wr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (wr_hit),
        .nib_i  (wdata_i),
        .cnt_i  (cnt),
        .run_i  (run_i),
        .irq_o  (irq_o),
        .phase_o(wr_ph),
        .armed_o(armed)
    );

    ntp_rd_seq #(.NW(NW)) u_rd (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (rd_hit),
        .pdm_i  (pdm_mode_i),
        .run_i  (run_i),
        .irq_i  (irq_o),
        .cnt_i  (cnt),
        .rdata_o(rdata_o),
        .phase_o(rd_ph),
        .cap_o  (cap)
    );
endmodule

// File: rtl/ntp_chk.sv
module ntp_chk
    import ntp_pkg::*;
#(
    parameter int unsigned NW = 4,
    localparam int unsigned W = 2 * NW
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         run_i,
    input logic         wr_hit_i,
    input logic         rd_hit_i,
    input logic [W-1:0] cnt_i,
    input logic         irq_i,
    input logic         armed_i,
    input phase_e       wr_ph_i,
    input phase_e       rd_ph_i,
    input logic [W-1:0] cap_i
);
    assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> (cnt_i == W'($past(cnt_i) + 1'b1)));

    assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> $stable(cnt_i));

    assert_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |=> !irq_i);

    assert_irq_midwrite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ph_i == PH_SECOND) |=> !irq_i);

    assert_irq_unarmed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed_i |=> !irq_i);

    assert_cap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_ph_i == PH_SECOND) && !rd_hit_i && run_i) |=> $stable(cap_i));

    assert_rd_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_hit_i |=> (rd_ph_i != $past(rd_ph_i)));

    assert_wr_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit_i |=> (wr_ph_i != $past(wr_ph_i)));
endmodule

bind nibble_timer_port ntp_chk #(.NW(NW)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .wr_hit_i(wr_hit),
    .rd_hit_i(rd_hit),
    .cnt_i   (cnt),
    .irq_i   (irq_o),
    .armed_i (armed),
    .wr_ph_i (wr_ph),
    .rd_ph_i (rd_ph),
    .cap_i   (cap)
);

// File: tb/nibble_timer_port_tb_top.sv
module nibble_timer_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       pdm = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr = 1'b0;
    logic [3:0] wdata = 4'h0;
    logic       rd = 1'b0;
    logic [3:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    // bench-side model built from the requirements
    logic [7:0] mcnt = 8'h00, mcmp = 8'h00, mcap = 8'h00;
    logic [3:0] mhold = 4'h0;
    bit mph = 0, mvalid = 0, mrph = 0, mevt = 0, irq_exp = 0;

    always #10 clk = ~clk;

    nibble_timer_port dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .run_i     (run),
        .pdm_mode_i(pdm),
        .sub_addr_i(addr),
        .wr_i      (wr),
        .wdata_i   (wdata),
        .rd_i      (rd),
        .rdata_o   (rdata),
        .irq_o     (irq)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            bit nirq, nevt;
            nirq = run && mvalid && !mph && (mcnt == mcmp);
            nevt = mevt | irq_exp;
            if (!run && mevt) begin
                mcap = 8'h00;
                nevt = 0;
            end
            mevt    = nevt;
            irq_exp = nirq;
            if (run) mcnt = mcnt + 8'd1;
        end
    end

    // monitor: every cycle the interrupt, and read data whenever a read strobe is up
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R3/R4 irq", {7'd0, irq}, {7'd0, irq_exp});
            if (irq) irq_seen++;
            if (rd) begin
                if (exp_q.size() == 0) begin
                    chk("R5 scoreboard empty", 8'd1, 8'd0);
                end else begin
                    logic [3:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, {4'd0, rdata}, {4'd0, e});
                end
            end else begin
                chk("R9 idle rdata", {4'd0, rdata}, 8'd0);
            end
        end
    end

    task automatic do_write(input logic [3:0] a, input logic [3:0] n);
        @(negedge clk);
        addr = a; wdata = n; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
        if (a == 4'h9) begin
            if (!mph) begin
                mhold = n; mph = 1;
            end else begin
                mcmp = {n, mhold}; mvalid = 1; mph = 0;
            end
        end
    endtask

    task automatic do_read(input logic [3:0] a, input string tag);
        logic [7:0] snap;
        logic [3:0] e;
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        snap = pdm ? rev8(mcnt) : mcnt;
        if (a != 4'h9) e = 4'h0;
        else if (!mrph) e = snap[7:4];
        else e = mcap[3:0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd = 1'b0;
        if (a == 4'h9) begin
            if (!mrph) begin
                mcap = snap; mrph = 1;
            end else begin
                mrph = 0;
            end
        end
    endtask

    task automatic irq_window(input int n, input int exp, input string tag);
        int start;
        start = irq_seen;
        repeat (n) @(negedge clk);
        #3;
        chk(tag, 8'(irq_seen - start), 8'(exp));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] c;
        repeat (3) @(negedge clk);
        chk("R9 reset rdata", {4'd0, rdata}, 8'd0);
        chk("R3 reset irq", {7'd0, irq}, 8'd0);
        rst_n = 1'b1;

        // halted counter reads zero (R1, R5)
        repeat (4) @(negedge clk);
        do_read(4'h9, "R1 halted hi");
        do_read(4'h9, "R1 halted lo");

        run = 1'b1;
        repeat (37) @(negedge clk);
        do_read(4'h9, "R5 hi");
        do_read(4'h9, "R5 lo");
        do_read(4'h9, "R6 hi");
        repeat (7) @(negedge clk);
        do_read(4'h9, "R6 held lo");
        do_read(4'h9, "R10 rephase hi");
        do_read(4'h9, "R10 rephase lo");

        // no compare written yet: no interrupt (R4)
        irq_window(300, 0, "R4 unarmed irq count");

        // full compare write, one match per wrap (R2, R3)
        #1 c = mcnt + 8'd40;
        do_write(4'h9, c[3:0]);
        do_write(4'h9, c[7:4]);
        irq_window(256, 1, "R2/R3 irq per wrap");

        // half-written compare blocks interrupts (R4)
        c = mcnt + 8'd90;
        do_write(4'h9, c[3:0]);
        irq_window(300, 0, "R4 midwrite irq count");
        do_write(4'h9, c[7:4]);
        irq_window(256, 1, "R2 new compare irq");

        // bit-reversed snapshot (R7)
        pdm = 1'b1;
        do_read(4'h9, "R7 rev hi");
        pdm = 1'b0;
        do_read(4'h9, "R7 rev lo");

        // other subport ignored (R9, R10)
        do_write(4'h3, 4'hA);
        do_write(4'h3, 4'h5);
        irq_window(256, 1, "R9 compare unchanged");
        do_read(4'h3, "R9 other addr read");
        do_read(4'h9, "R10 phase kept hi");
        do_read(4'h9, "R10 phase kept lo");

        // halt after interrupt clears the snapshot (R8)
        do_read(4'h9, "R8 first read");
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #3;
            if (irq) break;
        end
        @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 model cleared", mcap, 8'h00);
        do_read(4'h9, "R8 cleared lo");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule